// File: doc/BRIEF.md
# Debug Probe Control and Sense Register

This block is the register a debug probe's processor uses to steer the pins that face the target. From a small 32-bit bus slave it drives the target's system-reset and test-reset outputs, the target power switch, two indicator lamps, and the bit that tells the scan clock generator to run in adaptive (returned-clock) mode instead of from a fixed divider. It also gathers three events into flags that stay set until cleared. The first is the target's system-reset line seen asserted. The second is a loss of target power. The third is a timeout pulse from the clock generator in adaptive mode.

Software never does a read-modify-write. The bus has two write offsets. A 1 written at the set offset sets the matching bit, and a 1 written at the clear offset clears it. A 0 in either write leaves the bit alone, so independent drivers can touch separate bits without racing. A read at either offset returns the whole live word.

The two sensed target lines are asynchronous. Each passes through a flop synchronizer before it reaches its flag. Writing a 1 to a sensed flag's bit at the set offset re-arms the flag. It then reports whether the line is still asserted at that moment, which is how software samples the line and clears the flag in one step.

Top module: `probe_ctl_regs`

## Requirements
- R1: A write at offset 0x10 sets every implemented control bit whose write-data bit is 1. Control bits whose write-data bit is 0 keep their value.
- R2: A write at offset 0x14 clears every implemented control bit whose write-data bit is 1. Control bits whose write-data bit is 0 keep their value.
- R3: Bit 0 drives `srst_out`, bit 1 drives `trst_out`, bit 4 drives `led[0]`, bit 5 drives `led[1]` and bit 8 drives `rclk_mode`. Each output is high when its bit is 1, and the output changes on the clock edge that accepts the write.
- R4: Bit 3 is the power-off bit. `pwr_en` is low while bit 3 is 1 and high while bit 3 is 0.
- R5: After synchronous reset, `srst_out`, `trst_out`, `led` and `rclk_mode` are low, `pwr_en` is low, every flag is clear, and a read returns 0x0000_0008.
- R6: Bit 6 is set on the third rising clock edge after `srst_sense` goes high, which is two synchronizer stages and then the flag. The bit stays 1 after the line returns low.
- R7: Writing 1 to bit 6 at offset 0x10 loads bit 6 with the current synchronized `srst_sense` level. It therefore reads 1 if the line is still high and 0 otherwise. A 1 written to bit 6 at offset 0x14 has no effect.
- R8: Bit 7 records `pwr_drop` with the same synchronizer delay, sticky hold and re-arm rule as bit 6.
- R9: A one-cycle `rclk_timeout` pulse sets bit 10 at the next clock edge, and the bit holds until a 1 is written to bit 10 at offset 0x14. When a pulse and that clear arrive in the same cycle, the bit is set. A 1 written to bit 10 at offset 0x10 has no effect.
- R10: A read with `bus_sel` high at offset 0x10 or 0x14 returns the full word, with bits 2, 9 and 11 to 31 always 0. A read at any other offset returns 0, and writes at any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| srst_sense | input | 1 | Target system-reset line level (1 = asserted), asynchronous |
| pwr_drop | input | 1 | Target power-loss indication (1 = dropped), asynchronous |
| rclk_timeout | input | 1 | Single-cycle timeout pulse from the clock generator |
| srst_out | output | 1 | Drive system reset to the target |
| trst_out | output | 1 | Drive test reset to the target |
| pwr_en | output | 1 | Target power switch enable |
| led | output | 2 | Indicator lamps |
| rclk_mode | output | 1 | 1 = adaptive clock, 0 = fixed divider |

## Verification
The bench counts edges after a sensed line rises. A design with one synchronizer stage too many or too few would set the flag one edge early or late, and the bench reads on both sides of the expected edge to catch either. Re-arm is checked in two cases: with the line still high, where a design that only clears would wrongly read 0, and with the line low. A timeout pulse is made to coincide with its clear; if the clear wins, the event is lost. The bench writes all ones at both offsets and writes to a foreign offset. These show whether reserved bits read back as 1, whether the clear offset also re-arms the sensed flags, and whether the address decode is too loose.

// File: rtl/probe_ctl_pkg.sv
// Shared bit positions, masks and types for the probe control register.
// Bit positions are fixed because probe software decodes them.
package probe_ctl_pkg;

    localparam int DATA_W = 32;

    // Control bits
    localparam int B_SRST      = 0;
    localparam int B_TRST      = 1;
    localparam int B_PWR_OFF   = 3;
    localparam int B_LED0      = 4;
    localparam int B_LED1      = 5;
    localparam int B_RCLK      = 8;

    // Event flags
    localparam int B_SRST_SEEN = 6;
    localparam int B_DROP_SEEN = 7;
    localparam int B_RCLK_ERR  = 10;

    // Number of sensed input lines; their flags occupy consecutive bits
    localparam int N_SENSE     = 2;

    // Implemented plain control bits: 0,1,3,4,5,8
    localparam logic [DATA_W-1:0] CTL_MASK  = 32'h0000_013B;
    // Reset value: power switch off, everything else low
    localparam logic [DATA_W-1:0] CTL_RESET = 32'h0000_0008;

    // One decoded bus write
    typedef struct packed {
        logic              set_wr;
        logic              clr_wr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/probe_bus_decode.sv
// Address decode for the control register.
// Turns a bus access into a set-write, a clear-write, or a read hit.
// Assumes one access per cycle, with bus_sel qualifying bus_wr and bus_addr.
module probe_bus_decode
    import probe_ctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SET_OFS = 'h10,
    parameter int CLR_OFS = 'h14
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wr_req_t           req,
    output logic              rd_hit
);

    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    logic at_set;
    logic at_clr;

    // Compare the address against both register offsets
    always_comb begin
        at_set = (bus_addr == SET_A);
        at_clr = (bus_addr == CLR_A);
    end

    // Qualify the offset hits with the strobe and the direction
    always_comb begin
        req.set_wr = bus_sel && bus_wr && at_set;
        req.clr_wr = bus_sel && bus_wr && at_clr;
        req.data   = bus_wdata;
        rd_hit     = bus_sel && !bus_wr && (at_set || at_clr);
    end

endmodule

// File: rtl/probe_sync.sv
// Multi-stage flop synchronizer for asynchronous level inputs.
// Assumes the inputs are slow levels: a pulse shorter than a clock may be lost.
module probe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // First stage samples the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    // Remaining stages form a shift chain
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/probe_ctrl_bits.sv
// Holds the plain control bits under the set/clear write scheme.
// Only bits in CTL_MASK are stored. The other bits stay 0.
// Assumes set and clear writes never occur in the same cycle (different offsets).
module probe_ctrl_bits
    import probe_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_req_t           req,
    output logic [DATA_W-1:0] ctl
);

    logic [DATA_W-1:0] set_m;
    logic [DATA_W-1:0] clr_m;

    // Restrict both write masks to the implemented bits
    always_comb begin
        set_m = req.set_wr ? (req.data & CTL_MASK) : '0;
        clr_m = req.clr_wr ? (req.data & CTL_MASK) : '0;
    end

    // Apply the set mask, then the clear mask
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= CTL_RESET;
        else        ctl <= (ctl | set_m) & ~clr_m;
    end

endmodule

// File: rtl/probe_event_flags.sv
// Sticky event flags: one per synchronized sense line, plus the clock timeout.
// A sense flag ORs in its line each cycle. Re-arm reloads it with the live level.
// The timeout flag is set by a pulse and cleared by a write; a pulse wins a tie.
module probe_event_flags
    import probe_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SENSE-1:0] sense_lvl,
    input  logic [N_SENSE-1:0] rearm,
    input  logic               tmo_pulse,
    input  logic               tmo_clr,
    output logic [N_SENSE-1:0] sense_flag,
    output logic               tmo_flag
);

    for (genvar i = 0; i < N_SENSE; i++) begin : g_sense
        // Capture the line and hold it; re-arm samples the present level
        always_ff @(posedge clk) begin
            if (!rst_n)        sense_flag[i] <= 1'b0;
            else if (rearm[i]) sense_flag[i] <= sense_lvl[i];
            else               sense_flag[i] <= sense_flag[i] | sense_lvl[i];
        end
    end

    // Timeout error: the incoming pulse takes priority over the clear
    always_ff @(posedge clk) begin
        if (!rst_n)         tmo_flag <= 1'b0;
        else if (tmo_pulse) tmo_flag <= 1'b1;
        else if (tmo_clr)   tmo_flag <= 1'b0;
    end

endmodule

// File: rtl/probe_ctl_regs.sv
// Top of the debug probe control and sense register.
// Merges the control bits and the event flags into one word, read at either offset.
// Assumes srst_sense and pwr_drop are asynchronous levels.
// Assumes rclk_timeout is a single-cycle pulse in the clk domain.
module probe_ctl_regs
    import probe_ctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SET_OFS     = 'h10,
    parameter int CLR_OFS     = 'h14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              srst_sense,
    input  logic              pwr_drop,
    input  logic              rclk_timeout,
    output logic              srst_out,
    output logic              trst_out,
    output logic              pwr_en,
    output logic [1:0]        led,
    output logic              rclk_mode
);

    wr_req_t             req;
    logic                rd_hit;
    logic [DATA_W-1:0]   ctl;
    logic [N_SENSE-1:0]  sense_raw;
    logic [N_SENSE-1:0]  sense_sync;
    logic [N_SENSE-1:0]  sense_flag;
    logic [N_SENSE-1:0]  rearm;
    logic                tmo_flag;
    logic                tmo_clr;
    logic [DATA_W-1:0]   reg_word;

    probe_bus_decode #(
        .ADDR_W  (ADDR_W),
        .SET_OFS (SET_OFS),
        .CLR_OFS (CLR_OFS)
    ) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req       (req),
        .rd_hit    (rd_hit)
    );

    probe_ctrl_bits u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .ctl   (ctl)
    );

    // Gather the sensed lines in flag-bit order
    always_comb begin
        sense_raw[0] = srst_sense;
        sense_raw[1] = pwr_drop;
    end

    probe_sync #(
        .WIDTH  (N_SENSE),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sense_raw),
        .dout  (sense_sync)
    );

    // Re-arm only through the set offset; the timeout clears only through the clear offset
    always_comb begin
        rearm   = req.set_wr ? req.data[B_SRST_SEEN +: N_SENSE] : '0;
        tmo_clr = req.clr_wr && req.data[B_RCLK_ERR];
    end

    probe_event_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sense_lvl  (sense_sync),
        .rearm      (rearm),
        .tmo_pulse  (rclk_timeout),
        .tmo_clr    (tmo_clr),
        .sense_flag (sense_flag),
        .tmo_flag   (tmo_flag)
    );

    // Assemble the live register word
    always_comb begin
        reg_word                          = ctl;
        reg_word[B_SRST_SEEN +: N_SENSE]  = sense_flag;
        reg_word[B_RCLK_ERR]              = tmo_flag;
    end

    // Return the word only for a read hit
    always_comb begin
        bus_rdata = rd_hit ? reg_word : '0;
    end

    // Drive the target-facing pins from the control bits
    always_comb begin
        srst_out  = ctl[B_SRST];
        trst_out  = ctl[B_TRST];
        pwr_en    = !ctl[B_PWR_OFF];
        led[0]    = ctl[B_LED0];
        led[1]    = ctl[B_LED1];
        rclk_mode = ctl[B_RCLK];
    end

endmodule

// File: rtl/probe_ctl_regs_chk.sv
// Assertion checker for probe_ctl_regs, attached by bind.
// It watches the bus, the pins and the flag state and checks the rules over time.
module probe_ctl_regs_chk #(
    parameter int ADDR_W  = 8,
    parameter int SET_OFS = 'h10,
    parameter int CLR_OFS = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              srst_out,
    input logic              trst_out,
    input logic              pwr_en,
    input logic [1:0]        led,
    input logic              rclk_mode,
    input logic              rclk_timeout,
    input logic [1:0]        sense_sync,
    input logic [1:0]        sense_flag,
    input logic              tmo_flag
);

    logic set_w;
    logic clr_w;
    logic any_w;

    // Classify the current bus cycle independently of the design's decoder
    always_comb begin
        set_w = bus_sel && bus_wr && (bus_addr == ADDR_W'(SET_OFS));
        clr_w = bus_sel && bus_wr && (bus_addr == ADDR_W'(CLR_OFS));
        any_w = set_w || clr_w;
    end

    p_set_srst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && bus_wdata[0]) |=> srst_out);

    p_clr_trst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && bus_wdata[1]) |=> !trst_out);

    p_quiet_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_w |=> ($stable(srst_out) && $stable(trst_out) && $stable(led) && $stable(rclk_mode)));

    p_power_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && bus_wdata[3]) |=> !pwr_en);

    p_srst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_flag[0] && !(set_w && bus_wdata[6])) |=> sense_flag[0]);

    p_srst_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sense_sync[0] |=> sense_flag[0]);

    p_drop_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sense_sync[1] |=> sense_flag[1]);

    p_tmo_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rclk_timeout |=> tmo_flag);

    p_tmo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !(clr_w && bus_wdata[10])) |=> tmo_flag);

endmodule

bind probe_ctl_regs probe_ctl_regs_chk #(
    .ADDR_W  (ADDR_W),
    .SET_OFS (SET_OFS),
    .CLR_OFS (CLR_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .srst_out     (srst_out),
    .trst_out     (trst_out),
    .pwr_en       (pwr_en),
    .led          (led),
    .rclk_mode    (rclk_mode),
    .rclk_timeout (rclk_timeout),
    .sense_sync   (sense_sync),
    .sense_flag   (sense_flag),
    .tmo_flag     (tmo_flag)
);

// File: tb/probe_ctl_regs_tb.sv
// Directed bench for probe_ctl_regs: one task per scenario, each checking itself.
module probe_ctl_regs_tb;

    localparam logic [7:0] A_SET = 8'h10;
    localparam logic [7:0] A_CLR = 8'h14;
    localparam logic [7:0] A_BAD = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        srst_sense = 1'b0;
    logic        pwr_drop = 1'b0;
    logic        rclk_timeout = 1'b0;
    logic        srst_out;
    logic        trst_out;
    logic        pwr_en;
    logic [1:0]  led;
    logic        rclk_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    probe_ctl_regs u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .srst_sense   (srst_sense),
        .pwr_drop     (pwr_drop),
        .rclk_timeout (rclk_timeout),
        .srst_out     (srst_out),
        .trst_out     (trst_out),
        .pwr_en       (pwr_en),
        .led          (led),
        .rclk_mode    (rclk_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write cycle; the register has updated by the time this returns
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    // Combinational read, done away from the clock edge
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(A_SET, d);
        check("R5 reset word", d, 32'h8);
        check("R5 reset pins", {27'h0, srst_out, trst_out, pwr_en, led}, 32'h0);
        check("R5 reset rclk_mode", {31'h0, rclk_mode}, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] d;
        wr(A_SET, 32'h0000_0011);
        rd(A_SET, d);
        check("R1 set bits 0 and 4", d, 32'h19);
        wr(A_SET, 32'h0000_0002);
        rd(A_SET, d);
        check("R1 zero bits keep value", d, 32'h1B);
        wr(A_CLR, 32'h0000_0001);
        rd(A_CLR, d);
        check("R2 clear bit 0 only", d, 32'h1A);
        wr(A_CLR, 32'h0000_0000);
        rd(A_CLR, d);
        check("R2 zero clear has no effect", d, 32'h1A);
        wr(A_CLR, 32'h0000_001A);
    endtask

    task automatic t_mapping;
        // r3_ one pin at a time
        wr(A_SET, 32'h1);
        check("R3 bit0 -> srst_out", {27'h0, srst_out, trst_out, led, rclk_mode}, 32'h10);
        wr(A_CLR, 32'h1);
        wr(A_SET, 32'h2);
        check("R3 bit1 -> trst_out", {27'h0, srst_out, trst_out, led, rclk_mode}, 32'h08);
        wr(A_CLR, 32'h2);
        wr(A_SET, 32'h10);
        check("R3 bit4 -> led0", {27'h0, srst_out, trst_out, led, rclk_mode}, 32'h02);
        wr(A_CLR, 32'h10);
        wr(A_SET, 32'h20);
        check("R3 bit5 -> led1", {27'h0, srst_out, trst_out, led, rclk_mode}, 32'h04);
        wr(A_CLR, 32'h20);
        wr(A_SET, 32'h100);
        check("R3 bit8 -> rclk_mode", {27'h0, srst_out, trst_out, led, rclk_mode}, 32'h01);
        wr(A_CLR, 32'h100);
    endtask

    task automatic t_power;
        wr(A_CLR, 32'h8);
        check("R4 clear bit3 powers on", {31'h0, pwr_en}, 32'h1);
        wr(A_SET, 32'h8);
        check("R4 set bit3 powers off", {31'h0, pwr_en}, 32'h0);
    endtask

    task automatic t_srst_sense;
        logic [31:0] d;
        @(negedge clk) srst_sense = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(A_SET, d);
        check("R6 not yet after two edges", {31'h0, d[6]}, 32'h0);
        @(negedge clk);
        rd(A_SET, d);
        check("R6 set on third edge", {31'h0, d[6]}, 32'h1);
        wr(A_SET, 32'h40);
        rd(A_SET, d);
        check("R7 re-arm with line high reads 1", {31'h0, d[6]}, 32'h1);
        srst_sense = 1'b0;
        repeat (4) @(negedge clk);
        rd(A_SET, d);
        check("R6 sticky after line drops", {31'h0, d[6]}, 32'h1);
        wr(A_CLR, 32'h40);
        rd(A_SET, d);
        check("R7 clear offset ignored for bit6", {31'h0, d[6]}, 32'h1);
        wr(A_SET, 32'h40);
        rd(A_SET, d);
        check("R7 re-arm with line low reads 0", {31'h0, d[6]}, 32'h0);
    endtask

    task automatic t_drop_sense;
        logic [31:0] d;
        @(negedge clk) pwr_drop = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(A_SET, d);
        check("R8 not yet after two edges", {31'h0, d[7]}, 32'h0);
        @(negedge clk);
        pwr_drop = 1'b0;
        rd(A_SET, d);
        check("R8 set on third edge", {31'h0, d[7]}, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_SET, d);
        check("R8 sticky after recovery", {31'h0, d[7]}, 32'h1);
        wr(A_SET, 32'h80);
        rd(A_SET, d);
        check("R8 re-arm with line low reads 0", {31'h0, d[7]}, 32'h0);
    endtask

    task automatic t_timeout;
        logic [31:0] d;
        @(negedge clk) rclk_timeout = 1'b1;
        rd(A_SET, d);
        check("R9 not set before edge", {31'h0, d[10]}, 32'h0);
        @(negedge clk) rclk_timeout = 1'b0;
        rd(A_SET, d);
        check("R9 set one edge after pulse", {31'h0, d[10]}, 32'h1);
        repeat (3) @(negedge clk);
        wr(A_SET, 32'h400);
        rd(A_SET, d);
        check("R9 held, set offset ignored", {31'h0, d[10]}, 32'h1);
        wr(A_CLR, 32'h400);
        rd(A_SET, d);
        check("R9 cleared by clear offset", {31'h0, d[10]}, 32'h0);
        @(negedge clk);
        rclk_timeout = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h400;
        @(negedge clk);
        rclk_timeout = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
        rd(A_SET, d);
        check("R9 pulse wins over clear", {31'h0, d[10]}, 32'h1);
        wr(A_CLR, 32'h400);
    endtask

    task automatic t_readmap;
        logic [31:0] d;
        wr(A_SET, 32'hFFFF_FFFF);
        rd(A_CLR, d);
        check("R10 all-ones set, reserved read 0", d, 32'h0000_013B);
        rd(A_BAD, d);
        check("R10 foreign offset reads 0", d, 32'h0);
        wr(A_BAD, 32'h0);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_SET, d);
        check("R10 all-ones clear", d, 32'h0);
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_SET, d);
        check("R10 foreign write ignored", d, 32'h0);
        wr(A_SET, 32'h8);
    endtask

    initial begin
        t_reset();
        t_set_clear();
        t_mapping();
        t_power();
        t_srst_sense();
        t_drop_sense();
        t_timeout();
        t_readmap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule